// File: doc/BRIEF.md
# Four-Phase Shared Memory Wait Arbiter

This block lets a CPU and a video fetch unit share one synchronous RAM. A free-running phase counter splits time into windows of four clocks. Two fixed phases of each window are video fetch slots. One phase is the CPU slot. The fourth phase leaves the RAM port idle. The CPU is never interleaved on alternate clocks. Instead, its active-low wait line is held low for three phases of every window and released only during the CPU slot. A CPU machine cycle therefore always stretches to a whole multiple of four clocks. In the usual case this adds one clock to a memory access.

The RAM port assumes a one-clock synchronous read: data comes back in the clock after the address cycle. The block registers that data toward its consumer. Video bytes are presented with a one-clock valid pulse. CPU read data is held on a register until the next CPU read.

The phase assignment is a set of parameters. The defaults are video in phases 0 and 2, idle in phase 1, and CPU in phase 3.

Top module: `shmarb_wait_arbiter`

## Requirements
- R1: A synchronous reset clears the phase counter to 0, drives vid_valid low, holds cpu_wait_n low and clears cpu_rdata to zero.
- R2: The phase advances by one every clock, modulo 4, and the first clock after reset is phase 0. cpu_wait_n is high in phase 3 only, so it is high in exactly one clock of every four.
- R3: ram_we is asserted only in phase 3, and only when cpu_mreq and cpu_wr are high. The RAM then receives cpu_addr and cpu_wdata.
- R4: In phases 0 and 2, ram_en is high, ram_we is low and ram_addr equals vid_addr.
- R5: In phase 1, and in phase 3 when there is no CPU request (cpu_mreq low, or neither cpu_rd nor cpu_wr high), ram_en and ram_we are both low.
- R6: A CPU that raises a request and holds it sees cpu_wait_n high within 4 clocks, counting the clock in which the request is first present. Its access is issued to the RAM in that clock.
- R7: After a CPU read issued in clock k, cpu_rdata takes the RAM contents at cpu_addr at the rising edge that ends clock k+1. It holds that value until the next CPU read.
- R8: After a video slot in clock k, vid_valid is high for exactly clock k+2. During that clock, vid_data holds the RAM contents at the vid_addr presented in clock k.
- R9: A CPU write is visible to every later CPU read and video fetch of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_mreq | input | 1 | CPU memory request |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Latched CPU read data |
| cpu_wait_n | output | 1 | Active-low wait to the CPU |
| vid_addr | input | ADDR_W | Video fetch address |
| vid_data | output | DATA_W | Latched video byte |
| vid_valid | output | 1 | One-clock strobe marking vid_data |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one clock after the address |

## Verification
Port decisions (R2 to R5) are combinational from the phase. They are therefore checked in the same clock, at the falling edge, against a phase the bench counts from reset release.

Video results (R8) are due two clocks after the slot. The bench pushes each expected byte into a two-stage pipeline and compares vid_valid and vid_data at the stage that falls due.

CPU read data (R7) is sampled at the falling edge two clocks after the granted clock. Grant latency (R6) is counted in falling edges, from the request up to and including the clock in which cpu_wait_n is seen high.

// File: rtl/shmarb_pkg.sv
package shmarb_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,
      SLOT_VIDEO = 2'd1,
      SLOT_CPU   = 2'd2
   } slot_kind_t;

   typedef enum logic [1:0] {
      RET_NONE  = 2'd0,
      RET_VIDEO = 2'd1,
      RET_CPU   = 2'd2
   } ret_tag_t;

   localparam int PHASES  = 4;
   localparam int PHASE_W = 2;
endpackage

// File: rtl/shmarb_phase.sv
module shmarb_phase
   import shmarb_pkg::*;
#(
   parameter int CPU_SLOT   = 3,
   parameter int VID_SLOT_A = 0,
   parameter int VID_SLOT_B = 2
) (
   input  logic               clk,
   input  logic               rst,
   output logic [PHASE_W-1:0] phase,
   output slot_kind_t         kind
);
   logic [PHASES-1:0] vid_hit;
   logic [PHASES-1:0] cpu_hit;

   always_ff @(posedge clk) begin
      if (rst) phase <= '0;
      else     phase <= phase + 1'b1;
   end

   for (genvar p = 0; p < PHASES; p++) begin : g_slot
      localparam bit IS_VID = (p == VID_SLOT_A) || (p == VID_SLOT_B);
      localparam bit IS_CPU = (p == CPU_SLOT);
      assign vid_hit[p] = IS_VID && (phase == PHASE_W'(p));
      assign cpu_hit[p] = IS_CPU && (phase == PHASE_W'(p));
   end

   always_comb begin
      if (|cpu_hit)      kind = SLOT_CPU;
      else if (|vid_hit) kind = SLOT_VIDEO;
      else               kind = SLOT_IDLE;
   end
endmodule

// File: rtl/shmarb_port_mux.sv
module shmarb_port_mux
   import shmarb_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  slot_kind_t        kind,
   input  logic              cpu_mreq,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [ADDR_W-1:0] vid_addr,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output ret_tag_t          tag
);
   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = vid_addr;
      ram_wdata = '0;
      tag       = RET_NONE;
      unique case (kind)
         SLOT_VIDEO: begin
            ram_en = 1'b1;
            tag    = RET_VIDEO;
         end
         SLOT_CPU: begin
            if (cpu_mreq && cpu_wr) begin
               ram_en    = 1'b1;
               ram_we    = 1'b1;
               ram_addr  = cpu_addr;
               ram_wdata = cpu_wdata;
            end else if (cpu_mreq && cpu_rd) begin
               ram_en   = 1'b1;
               ram_addr = cpu_addr;
               tag      = RET_CPU;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/shmarb_return.sv
module shmarb_return
   import shmarb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  ret_tag_t          tag,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] vid_data,
   output logic              vid_valid,
   output logic [DATA_W-1:0] cpu_rdata
);
   ret_tag_t tag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tag_q     <= RET_NONE;
         vid_data  <= '0;
         vid_valid <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         tag_q     <= tag;
         vid_valid <= (tag_q == RET_VIDEO);
         if (tag_q == RET_VIDEO) vid_data  <= ram_rdata;
         if (tag_q == RET_CPU)   cpu_rdata <= ram_rdata;
      end
   end
endmodule

// File: rtl/shmarb_wait_arbiter.sv
module shmarb_wait_arbiter
   import shmarb_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int CPU_SLOT   = 3,
   parameter int VID_SLOT_A = 0,
   parameter int VID_SLOT_B = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_mreq,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_wait_n,
   input  logic [ADDR_W-1:0] vid_addr,
   output logic [DATA_W-1:0] vid_data,
   output logic              vid_valid,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("shmarb_wait_arbiter: widths must be positive");
   end
   if (CPU_SLOT >= PHASES || VID_SLOT_A >= PHASES || VID_SLOT_B >= PHASES) begin : g_bad_range
      $error("shmarb_wait_arbiter: slot index out of range");
   end
   if (CPU_SLOT == VID_SLOT_A || CPU_SLOT == VID_SLOT_B || VID_SLOT_A == VID_SLOT_B) begin : g_bad_overlap
      $error("shmarb_wait_arbiter: slots must be distinct");
   end

   logic [PHASE_W-1:0] phase;
   slot_kind_t         kind;
   ret_tag_t           tag;

   shmarb_phase #(
      .CPU_SLOT(CPU_SLOT), .VID_SLOT_A(VID_SLOT_A), .VID_SLOT_B(VID_SLOT_B)
   ) u_phase (
      .clk(clk), .rst(rst), .phase(phase), .kind(kind)
   );

   shmarb_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .kind(kind), .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .vid_addr(vid_addr),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .tag(tag)
   );

   shmarb_return #(.DATA_W(DATA_W)) u_ret (
      .clk(clk), .rst(rst), .tag(tag), .ram_rdata(ram_rdata),
      .vid_data(vid_data), .vid_valid(vid_valid), .cpu_rdata(cpu_rdata)
   );

   assign cpu_wait_n = (kind == SLOT_CPU);

   logic unused_phase;
   assign unused_phase = ^phase;
endmodule

// File: rtl/shmarb_checks.sv
module shmarb_checks #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_mreq,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              cpu_wait_n,
   input logic [ADDR_W-1:0] vid_addr,
   input logic              vid_valid,
   input logic              ram_en,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata
);
   logic [2:0] gap_cnt;
   logic [2:0] hold_cnt;
   logic       cpu_req;

   assign cpu_req = cpu_mreq && (cpu_rd || cpu_wr);

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_cnt  <= '0;
         hold_cnt <= '0;
      end else begin
         gap_cnt  <= cpu_wait_n ? 3'd0 : (gap_cnt == 3'd7 ? gap_cnt : gap_cnt + 3'd1);
         hold_cnt <= (cpu_req && !cpu_wait_n) ? (hold_cnt == 3'd7 ? hold_cnt : hold_cnt + 3'd1) : 3'd0;
      end
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (!vid_valid && !cpu_wait_n && cpu_rdata == '0));

   assert_wait_single_R2: assert property (@(posedge clk) disable iff (rst)
      cpu_wait_n |=> !cpu_wait_n);

   assert_wait_gap_R2: assert property (@(posedge clk) disable iff (rst)
      gap_cnt <= 3'd3);

   assert_write_in_cpu_slot_R3: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> (cpu_wait_n && cpu_mreq && cpu_wr && ram_addr == cpu_addr && ram_wdata == cpu_wdata));

   assert_video_port_R4: assert property (@(posedge clk) disable iff (rst)
      (ram_en && !cpu_wait_n) |-> (!ram_we && ram_addr == vid_addr));

   assert_idle_cpu_slot_R5: assert property (@(posedge clk) disable iff (rst)
      (cpu_wait_n && !cpu_req) |-> !ram_en);

   assert_grant_latency_R6: assert property (@(posedge clk) disable iff (rst)
      hold_cnt <= 3'd3);

   assert_vid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      vid_valid |=> !vid_valid);

   assert_vid_source_R8: assert property (@(posedge clk) disable iff (rst)
      vid_valid |-> $past(ram_en && !cpu_wait_n, 2));
endmodule

bind shmarb_wait_arbiter shmarb_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
   .clk(clk), .rst(rst), .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
   .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
   .cpu_wait_n(cpu_wait_n), .vid_addr(vid_addr), .vid_valid(vid_valid),
   .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
);

// File: tb/shmarb_wait_arbiter_test.sv
module shmarb_wait_arbiter_test;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cpu_mreq = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_wait_n;
   logic [AW-1:0] vid_addr = '0;
   logic [DW-1:0] vid_data;
   logic          vid_valid;
   logic          ram_en, ram_we;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata = '0;

   logic [DW-1:0] ram_mem [DEPTH];
   logic [DW-1:0] ref_mem [DEPTH];

   int  n_checks = 0;
   int  n_fails  = 0;
   int  cyc      = 0;
   bit  mon_on   = 1'b0;
   bit  drv_on   = 1'b0;
   bit  s1_v = 1'b0, s2_v = 1'b0;
   logic [DW-1:0] s1_d = '0, s2_d = '0;

   always #4 clk = ~clk;

   shmarb_wait_arbiter uut (
      .clk(clk), .rst(rst), .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_wait_n(cpu_wait_n), .vid_addr(vid_addr), .vid_data(vid_data),
      .vid_valid(vid_valid), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   function automatic logic [DW-1:0] init_byte(int a);
      return DW'(a * 7 + 3);
   endfunction

   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) ram_mem[ram_addr] <= ram_wdata;
         ram_rdata <= ram_mem[ram_addr];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (drv_on) vid_addr = AW'($urandom);
      end
   end

   always @(negedge clk) begin
      if (mon_on) begin
         int ph;
         bit req, nv;
         logic [DW-1:0] nd;
         ph  = cyc % 4;
         req = cpu_mreq && (cpu_rd || cpu_wr);
         chk(cpu_wait_n == (ph == 3), "R2", "wait_n pattern", cpu_wait_n, ph == 3);
         if (ram_we) chk(ph == 3 && req && cpu_wr, "R3", "write outside cpu slot", ph, 3);
         if (ph == 0 || ph == 2)
            chk(ram_en && !ram_we && ram_addr == vid_addr, "R4", "video port addr",
                ram_addr, vid_addr);
         if (ph == 1 || (ph == 3 && !req))
            chk(!ram_en && !ram_we, "R5", "idle port", {ram_en, ram_we}, 0);
         chk(vid_valid == s2_v, "R8", "vid_valid", vid_valid, s2_v);
         if (s2_v) chk(vid_data == s2_d, "R8", "vid_data", vid_data, s2_d);
         nv = (ph == 0 || ph == 2);
         nd = nv ? ref_mem[vid_addr] : '0;
         s2_v = s1_v; s2_d = s1_d;
         s1_v = nv;   s1_d = nd;
         cyc++;
      end
   end

   task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int waited;
      logic [DW-1:0] exp;
      @(posedge clk);
      #1;
      cpu_mreq = 1'b1; cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
      waited = 0;
      forever begin
         @(negedge clk);
         waited++;
         if (cpu_wait_n || waited > 8) break;
      end
      chk(waited <= 4, "R6", "grant latency", waited, 4);
      if (wr) ref_mem[a] = d;
      exp = ref_mem[a];
      @(posedge clk);
      #1;
      cpu_mreq = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
      if (!wr) begin
         @(negedge clk);
         @(negedge clk);
         chk(cpu_rdata == exp, "R7", "cpu read data", cpu_rdata, exp);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) begin
         ram_mem[i] = init_byte(i);
         ref_mem[i] = init_byte(i);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!vid_valid && !cpu_wait_n && cpu_rdata == '0 && !ram_we, "R1", "reset state",
          {vid_valid, cpu_wait_n, ram_we}, 0);
      @(posedge clk);
      #1;
      rst = 1'b0; mon_on = 1'b1; drv_on = 1'b1;
      repeat (10) @(posedge clk);
      // directed: R9 write then read back, video sees it too
      cpu_op(1'b1, 8'h55, 8'hA5);
      cpu_op(1'b0, 8'h55, 8'h00);
      cpu_op(1'b0, 8'h12, 8'h00);
      cpu_op(1'b1, 8'h00, 8'h3C);
      cpu_op(1'b1, 8'hFF, 8'hC3);
      cpu_op(1'b0, 8'hFF, 8'h00);
      cpu_op(1'b0, 8'h00, 8'h00);
      // random mix, narrow address range for reuse (R9)
      for (int n = 0; n < 600; n++) begin
         int idle;
         idle = $urandom_range(0, 5);
         repeat (idle) @(posedge clk);
         cpu_op(1'($urandom), AW'($urandom_range(0, 15)), DW'($urandom));
      end
      repeat (8) @(posedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule